// File: doc/BRIEF.md
# Board-Control Interrupt and Status Register Block

This block sits on a simple synchronous register bus and gathers sixteen external, level-sensitive interrupt lines into one host interrupt. Each line is first brought into the clock domain through a two-flop synchronizer. A line that is high while its enable bit is set marks its bit in a pending register. The single interrupt output is raised while any pending bit is also enabled. Software reads the pending register to find the source. It clears a bit by writing the pending register with that bit at zero. A line that is still high and enabled marks its bit again.

The same address space holds eight plain 32-bit scratch and control registers, used for LEDs, switches and miscellaneous board control. It also holds two card-socket status registers. In each socket register, software may change only the power and reset field. A card-detect bit tracks one of the interrupt lines, inverted, and the remaining bits are fixed after reset.

Top module: `brd_irq_regs`

## Requirements
- R1: After reset, irq_o is 0. All registers read as 0x00000000, except both socket status registers, which read 0x00000420: ready at bit 10 and card-absent at bit 5.
- R2: Three clock edges after an interrupt line rises, its pending bit (bit n for line n, read at offset 0xD0) is set if the enable bit n (offset 0xC0) is 1. The bit stays set after the line falls. A high line whose enable bit is 0 leaves its pending bit unchanged.
- R3: irq_o is 1 exactly one cycle after the bitwise AND of the pending and enable registers is nonzero, and 0 one cycle after it is zero.
- R4: A write to the enable register or the pending register stores the written data ANDed with 0x000FEEFF. Bits outside that mask always read as 0.
- R5: Writing 0 to a pending bit clears it, unless its line is high and enabled in that cycle. In that case the bit stays set.
- R6: Bit 5 of socket-0 status (offset 0xE0) is the inverse of synchronized line 9. Bit 5 of socket-1 status (offset 0xE4) is the inverse of synchronized line 13.
- R7: A write to a socket status register changes only bits [4:0]. Bits [31:6] keep their value, and bit 5 still follows its line.
- R8: The offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 are independent 32-bit read/write registers.
- R9: A read from any other offset returns 0. A write to any other offset changes no register.
- R10: rd_data is loaded on the clock edge that samples rd_en and then holds. It shows the register value from before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Asynchronous level-sensitive interrupt lines |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered combined interrupt to the host |

## Verification
The assertions check on every cycle the behaviour that relates state from one cycle to the next:
- irq_o follows the masked pending state from the cycle before;
- reserved pending and enable bits stay at zero;
- no pending bit rises without an enabled high line or a host write;
- an enabled high line always leaves its bit set;
- the card-detect bits mirror their lines;
- the upper socket bits never move.

Only the bench scenarios show what is seen through the bus:
- the exact read values after masked writes;
- that a clear loses to a live input;
- that unlisted offsets touch nothing;
- the old-value rule for a read and write in the same cycle.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int NUM_PLAIN = 8;
  localparam int NUM_SOCK  = 2;
  localparam logic [11:0] EN_OFF   = 12'h0C0;
  localparam logic [11:0] PEND_OFF = 12'h0D0;

  function automatic logic [11:0] plain_off(input int idx);
    case (idx)
      0:       return 12'h010;
      1:       return 12'h014;
      2:       return 12'h040;
      3:       return 12'h060;
      4:       return 12'h080;
      5:       return 12'h084;
      6:       return 12'h088;
      default: return 12'h090;
    endcase
  endfunction

  function automatic logic [11:0] sock_off(input int idx);
    return (idx == 0) ? 12'h0E0 : 12'h0E4;
  endfunction
endpackage

// File: rtl/brd_sync.sv
module brd_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core #(
  parameter int          DW      = 32,
  parameter int          NIRQ    = 16,
  parameter logic [31:0] KEEP    = 32'h000F_EEFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] lvl,
  input  logic            en_we,
  input  logic            pend_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   en_q,
  output logic [DW-1:0]   pend_q,
  output logic            irq_o
);
  localparam logic [DW-1:0] KEEP_W = DW'(KEEP);

  logic [DW-1:0] lvl_w;
  logic [DW-1:0] pend_base;
  logic [DW-1:0] pend_nxt;

  assign lvl_w = DW'(lvl);

  // input setting wins over a same-cycle host clear
  always_comb begin
    pend_base = pend_we ? (wdata & KEEP_W) : pend_q;
    pend_nxt  = pend_base | (lvl_w & en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (en_we) en_q <= wdata & KEEP_W;
      pend_q <= pend_nxt;
      irq_o  <= |(pend_q & en_q);
    end
  end
endmodule

// File: rtl/brd_sock_stat.sv
module brd_sock_stat #(
  parameter int          DW      = 32,
  parameter int          WR_BITS = 5,
  parameter int          CD_BIT  = 5,
  parameter logic [31:0] RST_VAL = 32'h0000_0420
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          cd_level,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_q;
    if (we) stat_nxt[WR_BITS-1:0] = wdata[WR_BITS-1:0];
    stat_nxt[CD_BIT] = ~cd_level;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= DW'(RST_VAL);
    else     stat_q <= stat_nxt;
  end
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
  import brd_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          NUM_IRQ  = 16,
  parameter logic [31:0] IRQ_KEEP = 32'h000F_EEFF,
  parameter int          CD0_LINE = 9,
  parameter int          CD1_LINE = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_o
);
  localparam int CD_LINE [NUM_SOCK] = '{CD0_LINE, CD1_LINE};

  logic [NUM_IRQ-1:0] lvl;
  logic [DATA_W-1:0]  en_q;
  logic [DATA_W-1:0]  pend_q;
  logic               en_we;
  logic               pend_we;
  logic [DATA_W-1:0]  plain_q [NUM_PLAIN];
  logic [DATA_W-1:0]  sock_q  [NUM_SOCK];
  logic [DATA_W-1:0]  rd_mux;

  brd_sync #(.W(NUM_IRQ)) u_sync (
    .clk(clk), .rst(rst), .async_in(irq_in), .sync_out(lvl)
  );

  assign en_we   = wr_en && (addr == ADDR_W'(EN_OFF));
  assign pend_we = wr_en && (addr == ADDR_W'(PEND_OFF));

  brd_irq_core #(.DW(DATA_W), .NIRQ(NUM_IRQ), .KEEP(IRQ_KEEP)) u_core (
    .clk(clk), .rst(rst), .lvl(lvl), .en_we(en_we), .pend_we(pend_we),
    .wdata(wr_data), .en_q(en_q), .pend_q(pend_q), .irq_o(irq_o)
  );

  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst) plain_q[g] <= '0;
      else if (wr_en && (addr == ADDR_W'(plain_off(g)))) plain_q[g] <= wr_data;
    end
  end

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    brd_sock_stat #(.DW(DATA_W)) u_sock (
      .clk(clk), .rst(rst),
      .we(wr_en && (addr == ADDR_W'(sock_off(s)))),
      .wdata(wr_data), .cd_level(lvl[CD_LINE[s]]), .stat_q(sock_q[s])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PLAIN; i++)
      if (addr == ADDR_W'(plain_off(i))) rd_mux = plain_q[i];
    for (int s = 0; s < NUM_SOCK; s++)
      if (addr == ADDR_W'(sock_off(s))) rd_mux = sock_q[s];
    if (addr == ADDR_W'(EN_OFF))   rd_mux = en_q;
    if (addr == ADDR_W'(PEND_OFF)) rd_mux = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/brd_irq_regs_chk.sv
module brd_irq_regs_chk #(
  parameter int          DW   = 32,
  parameter int          NIRQ = 16,
  parameter logic [31:0] KEEP = 32'h000F_EEFF,
  parameter int          CD0  = 9,
  parameter int          CD1  = 13
) (
  input logic            clk,
  input logic            rst,
  input logic [NIRQ-1:0] lvl,
  input logic [DW-1:0]   en_q,
  input logic [DW-1:0]   pend_q,
  input logic            irq_o,
  input logic            pend_we,
  input logic [DW-1:0]   wr_data,
  input logic [DW-1:0]   sock0,
  input logic [DW-1:0]   sock1
);
  localparam logic [DW-1:0] KEEP_W = DW'(KEEP);

  p_irq_follows_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == $past(|(pend_q & en_q)));

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
    ((pend_q | en_q) & ~KEEP_W) == '0);

  p_set_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((DW'($past(lvl)) & $past(en_q)) & ~pend_q) == '0);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q)) & ~(DW'($past(lvl)) & $past(en_q))
              & ~($past(pend_we) ? $past(wr_data) : '0)) == '0);

  p_cd_mirror_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sock0[5] == ~$past(lvl[CD0])) && (sock1[5] == ~$past(lvl[CD1])));

  p_sock_upper_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(sock0[DW-1:6]) && $stable(sock1[DW-1:6]));
endmodule

bind brd_irq_regs brd_irq_regs_chk #(
  .DW(DATA_W), .NIRQ(NUM_IRQ), .KEEP(IRQ_KEEP), .CD0(CD0_LINE), .CD1(CD1_LINE)
) u_chk (
  .clk(clk), .rst(rst), .lvl(lvl), .en_q(en_q), .pend_q(pend_q),
  .irq_o(irq_o), .pend_we(pend_we), .wr_data(wr_data),
  .sock0(sock_q[0]), .sock1(sock_q[1])
);

// File: tb/brd_irq_regs_tb.sv
module brd_irq_regs_tb;
  localparam logic [31:0] KEEP = 32'h000F_EEFF;
  localparam int WD_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] m_plain [8];
  logic [11:0] offs [8] = '{12'h010, 12'h014, 12'h040, 12'h060,
                            12'h080, 12'h084, 12'h088, 12'h090};

  always #2 clk = ~clk;

  brd_irq_regs u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  function automatic bit listed(input logic [11:0] a);
    for (int i = 0; i < 8; i++) if (a == offs[i]) return 1;
    return (a == 12'h0C0 || a == 12'h0D0 || a == 12'h0E0 || a == 12'h0E4);
  endfunction

  function automatic logic [31:0] sock_exp(input logic [4:0] low, input logic line);
    return 32'h0000_0400 | {26'd0, ~line, low};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    logic [31:0] v, en_m, d;
    logic [15:0] lines;
    logic [11:0] a;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_plain[i] = '0;
    idle(3); rst = 1'b0; idle(1);

    // R1 reset state
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    for (int i = 0; i < 8; i++) rd_chk("R1 plain", offs[i], 32'd0);
    rd_chk("R1 enable", 12'h0C0, 32'd0);
    rd_chk("R1 pending", 12'h0D0, 32'd0);
    rd_chk("R1 sock0", 12'h0E0, 32'h420);
    rd_chk("R1 sock1", 12'h0E4, 32'h420);

    // R8 plain registers, random
    for (int k = 0; k < 40; k++) begin
      int idx = $urandom % 8;
      d = $urandom;
      wr(offs[idx], d); m_plain[idx] = d;
      idx = $urandom % 8;
      rd_chk("R8 plain readback", offs[idx], m_plain[idx]);
    end

    // R9 unlisted offsets
    for (int k = 0; k < 20; k++) begin
      do a = 12'($urandom); while (listed(a));
      wr(a, $urandom);
      rd_chk("R9 unlisted read", a, 32'd0);
    end
    for (int i = 0; i < 8; i++) rd_chk("R9 plain untouched", offs[i], m_plain[i]);
    rd_chk("R9 enable untouched", 12'h0C0, 32'd0);
    rd_chk("R9 sock0 untouched", 12'h0E0, 32'h420);

    // R4 masks, R3 output
    wr(12'h0C0, 32'hFFFF_FFFF);
    rd_chk("R4 enable mask", 12'h0C0, KEEP);
    wr(12'h0D0, 32'hFFFF_FFFF);
    rd_chk("R4 pending mask", 12'h0D0, KEEP);
    idle(1);
    check("R3 irq high", {31'd0, irq_o}, 32'd1);
    for (int k = 0; k < 20; k++) begin
      en_m = $urandom; d = $urandom;
      wr(12'h0C0, en_m); wr(12'h0D0, d);
      rd_chk("R4 random enable", 12'h0C0, en_m & KEEP);
      rd_chk("R4 random pending", 12'h0D0, d & KEEP);
      check("R3 irq random", {31'd0, irq_o}, {31'd0, |(en_m & d & KEEP)});
    end
    wr(12'h0D0, 32'd0); wr(12'h0C0, 32'd0); idle(1);
    check("R3 irq low", {31'd0, irq_o}, 32'd0);

    // R2 disabled line does nothing, enabled sets and latches
    irq_in = 16'h0010; idle(5);
    rd_chk("R2 disabled line", 12'h0D0, 32'd0);
    check("R3 irq stays low", {31'd0, irq_o}, 32'd0);
    wr(12'h0C0, 32'h0000_0008); irq_in = 16'h0008; idle(5);
    rd_chk("R2 enabled set", 12'h0D0, 32'h8);
    check("R3 irq from line", {31'd0, irq_o}, 32'd1);
    // R5 clear loses while line high and enabled
    wr(12'h0D0, 32'd0);
    rd_chk("R5 clear blocked", 12'h0D0, 32'h8);
    irq_in = '0; idle(5);
    rd_chk("R2 latched after fall", 12'h0D0, 32'h8);
    wr(12'h0D0, 32'd0); idle(2);
    rd_chk("R5 clear works", 12'h0D0, 32'd0);
    check("R3 irq cleared", {31'd0, irq_o}, 32'd0);

    // R2 random lines and enables
    for (int k = 0; k < 20; k++) begin
      lines = 16'($urandom); en_m = $urandom & KEEP;
      irq_in = '0; idle(3);
      wr(12'h0C0, en_m); wr(12'h0D0, 32'd0);
      irq_in = lines; idle(5);
      rd_chk("R2 random pending", 12'h0D0, {16'd0, lines} & en_m);
      check("R3 irq random lines", {31'd0, irq_o}, {31'd0, |({16'd0, lines} & en_m)});
      rd_chk("R6 sock0 random", 12'h0E0, sock_exp(5'd0, lines[9]));
      rd_chk("R6 sock1 random", 12'h0E4, sock_exp(5'd0, lines[13]));
    end
    irq_in = '0; wr(12'h0C0, 32'd0); wr(12'h0D0, 32'd0); idle(3);

    // R6 / R7 sockets
    wr(12'h0E0, 32'hFFFF_FFFF);
    rd_chk("R7 sock0 write low bits", 12'h0E0, sock_exp(5'h1F, 1'b0));
    wr(12'h0E4, 32'h0000_0000);
    rd_chk("R7 sock1 clear attempt", 12'h0E4, sock_exp(5'h00, 1'b0));
    irq_in[9] = 1'b1; idle(4);
    rd_chk("R6 line9 detect", 12'h0E0, sock_exp(5'h1F, 1'b1));
    rd_chk("R6 sock1 unaffected", 12'h0E4, sock_exp(5'h00, 1'b0));
    irq_in[13] = 1'b1; idle(4);
    wr(12'h0E4, 32'hFFFF_FFEA);
    rd_chk("R6 R7 line13 detect", 12'h0E4, sock_exp(5'h0A, 1'b1));
    irq_in = '0; idle(4);
    rd_chk("R6 line9 removed", 12'h0E0, sock_exp(5'h1F, 1'b0));

    // R10 read in same cycle as write returns old value, then holds
    @(negedge clk); addr = offs[2]; wr_data = 32'hA5A5_5A5A; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; v = rd_data;
    check("R10 old value", v, m_plain[2]);
    m_plain[2] = 32'hA5A5_5A5A;
    addr = offs[5]; idle(3);
    check("R10 holds", rd_data, v);
    rd_chk("R10 new value", offs[2], m_plain[2]);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule